// File: doc/BRIEF.md
# Bus-Locked Atomic Exchange Unit

This block turns one processor request into an indivisible read-then-write on a shared memory bus. The processor hands it an address, an operation and a new value. The unit requests the bus and waits for a grant. It reads the addressed word and then writes the new word to the same address. Its lock output stays high from the read through the write, so the arbiter cannot let any other master in between them. When the write is acknowledged, the unit returns the word that was in memory before the write.

Two operations are offered. A swap stores the supplied word. A test-and-set stores the constant one, whatever word comes with the request. For a lock word, a returned zero means the requester has just taken the lock. A returned one means another agent already held it, and memory still reads one after the operation.

Top module: `xchg_unit`

## Requirements
- R1: While reset is applied and after it is released, the unit is idle: `req_ready` is high and `bus_req`, `bus_lock`, `bus_cmd_valid` and `rsp_done` are low.
- R2: `req_ready` is high only when the unit is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `bus_req` stays high up to and including the cycle in which the write is acknowledged.
- R3: `bus_cmd_valid` is never high unless `bus_gnt` is high. While the unit waits for a grant it presents no command.
- R4: The first command of an operation is a read (`bus_we` = 0) and the second is a write (`bus_we` = 1). Both use the address taken with the request. A command stays presented until `bus_ack`.
- R5: A swap (`req_op` = 0) writes `req_wdata`. A test-and-set (`req_op` = 1) writes the value 1 (bit 0 set, all other bits clear) and ignores `req_wdata`.
- R6: `bus_lock` is high from the first cycle the read command is presented through the cycle the write is acknowledged, without a gap. It is low at all other times.
- R7: `rsp_done` is high for exactly the one cycle in which the write is acknowledged. In that cycle `rsp_old` carries the data returned by the read.
- R8: A competing master that asks for the bus during the locked read-write pair is served only after the pair completes, so its write lands after the unit's write.
- R9: While the unit is busy, `req_valid` has no effect: the address and data in flight are unchanged, and no further memory word is touched.
- R10: A test-and-set on a word holding 0 returns 0 and leaves 1 stored. A second test-and-set on the same word returns 1 and leaves 1 stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Processor presents an atomic request |
| req_op | input | 1 | 0 = swap, 1 = test-and-set |
| req_addr | input | AW | Word address of the request |
| req_wdata | input | DW | Word to store for a swap |
| req_ready | output | 1 | Unit idle and able to take a request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_old | output | DW | Memory word seen before the write |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Arbiter grants the bus to this unit |
| bus_lock | output | 1 | Hold ownership across the read-write pair |
| bus_cmd_valid | output | 1 | Bus command presented |
| bus_we | output | 1 | 0 = read, 1 = write |
| bus_addr | output | AW | Command address |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Command completes in this cycle |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |

## Verification
The hardest case to reach is another master arriving at the one point where the lock matters: after the read is acknowledged and before the write starts. The bench models an arbiter that re-arbitrates after every acknowledge unless the lock is high. It gives a scripted competing master priority whenever it re-arbitrates. It starts that master's write to the same lock word only once the unit's read is under way. With slow acknowledges, the competitor's request is pending at the moment the read completes. If the lock dropped there, the competitor's write would fall between the unit's read and write, and the final memory word and the completion order would both show it.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ARB   = 2'd1,
    XS_READ  = 2'd2,
    XS_WRITE = 2'd3
  } xchg_state_e;

  typedef enum logic {
    XOP_SWAP = 1'b0,
    XOP_TAS  = 1'b1
  } xchg_op_e;

endpackage

// File: rtl/xchg_rst_sync.sv
module xchg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/xchg_seq.sv
module xchg_seq
  import xchg_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic req_valid,
  output logic req_ready,
  output logic rsp_done,
  output logic bus_req,
  input  logic bus_gnt,
  output logic bus_lock,
  output logic bus_cmd_valid,
  output logic bus_we,
  input  logic bus_ack,
  output logic cap_req,
  output logic cap_old
);

  xchg_state_e state_q, state_d;
  logic        state_en;

  // next state and outputs
  always_comb begin
    state_d       = state_q;
    req_ready     = 1'b0;
    rsp_done      = 1'b0;
    bus_req       = 1'b0;
    bus_lock      = 1'b0;
    bus_cmd_valid = 1'b0;
    bus_we        = 1'b0;
    cap_req       = 1'b0;
    cap_old       = 1'b0;
    unique case (state_q)
      XS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          cap_req = 1'b1;
          state_d = XS_ARB;
        end
      end
      XS_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt) state_d = XS_READ;
      end
      XS_READ: begin
        bus_req       = 1'b1;
        bus_lock      = 1'b1;
        bus_cmd_valid = bus_gnt;
        if (bus_gnt && bus_ack) begin
          cap_old = 1'b1;
          state_d = XS_WRITE;
        end
      end
      XS_WRITE: begin
        bus_req       = 1'b1;
        bus_lock      = 1'b1;
        bus_cmd_valid = bus_gnt;
        bus_we        = 1'b1;
        if (bus_gnt && bus_ack) begin
          rsp_done = 1'b1;
          state_d  = XS_IDLE;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // R6
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(bus_lock) |-> $past(rsp_done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_done |=> !rsp_done);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_req && !rsp_done) |=> bus_req);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_cmd_valid && !bus_we && bus_ack) |=> (bus_lock && (!bus_cmd_valid || bus_we)));

endmodule

// File: rtl/xchg_dp.sv
module xchg_dp
  import xchg_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cap_req,
  input  logic          cap_old,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] old_q
);

  localparam logic [DW-1:0] TAS_WORD = DW'(1);

  logic [DW-1:0] wdata_d;

  always_comb begin
    if (xchg_op_e'(req_op) == XOP_TAS) wdata_d = TAS_WORD;
    else                               wdata_d = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_req) begin
      addr_q  <= req_addr;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      old_q <= '0;
    end else if (cap_old) begin
      old_q <= bus_rdata;
    end
  end

endmodule

// File: rtl/xchg_unit.sv
module xchg_unit #(
  parameter int AW         = 16,
  parameter int DW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_old,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_lock,
  output logic          bus_cmd_valid,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata
);

  logic rst_int_n;
  logic cap_req, cap_old;

  xchg_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  xchg_seq u_seq (
    .clk           (clk),
    .rst_ni        (rst_int_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_done      (rsp_done),
    .bus_req       (bus_req),
    .bus_gnt       (bus_gnt),
    .bus_lock      (bus_lock),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_we        (bus_we),
    .bus_ack       (bus_ack),
    .cap_req       (cap_req),
    .cap_old       (cap_old)
  );

  xchg_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst_ni    (rst_int_n),
    .cap_req   (cap_req),
    .cap_old   (cap_old),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_rdata (bus_rdata),
    .addr_q    (bus_addr),
    .wdata_q   (bus_wdata),
    .old_q     (rsp_old)
  );

  // R9
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_ready) |=> (req_ready || $stable(bus_addr)));

endmodule

// File: tb/tb_xchg_unit.sv
`timescale 1ns/1ps
module tb_xchg_unit;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_done;
  logic [DW-1:0] rsp_old;
  logic          bus_req, bus_gnt, bus_lock, bus_cmd_valid, bus_we, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #4 clk = ~clk; // 125 MHz

  xchg_unit #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_old(rsp_old), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_lock(bus_lock), .bus_cmd_valid(bus_cmd_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int errors = 0, checks = 0, cycle = 0;
  logic [DW-1:0] mem [16];

  // bus model state: owner 0 none, 1 unit, 2 competitor
  int owner = 0, lat = 1, lat_cnt = 0;
  logic ack_on = 1'b0;
  int comp_req_cnt = 0, comp_served = 0;
  logic [3:0]    comp_addr;
  logic [DW-1:0] comp_val;
  int comp_end_cyc = 0, unit_done_cyc = 0;

  // reference model
  int ph = 0;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_wdata, rd_val, last_old;
  int n_done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (cycle %0d)", req, what, act, exp, cycle);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference phase update at the active edge
  always @(posedge clk) begin
    if (!rst_n) ph <= 0;
    else begin
      case (ph)
        0: if (req_valid) begin
             ph <= 1; e_addr <= req_addr;
             e_wdata <= req_op ? DW'(1) : req_wdata;
           end
        1: if (bus_gnt) ph <= 2;
        2: if (bus_gnt && bus_ack) begin ph <= 3; rd_val <= bus_rdata; end
        3: if (bus_gnt && bus_ack) ph <= 0;
        default: ph <= 0;
      endcase
    end
  end

  // per-cycle comparison, away from the edge
  always @(negedge clk) begin
    #2;
    cycle++;
    if (cycle > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycle);
      finish_run();
    end
    if (!rst_n) begin
      // R1
      chk(req_ready && !bus_req && !bus_lock && !bus_cmd_valid && !rsp_done, "R1", "idle in reset",
          {req_ready, bus_req, bus_lock, bus_cmd_valid, rsp_done}, 32'h10);
    end else begin
      chk(req_ready == (ph == 0), "R2", "req_ready", req_ready, (ph == 0));
      chk(bus_req == (ph != 0), "R2", "bus_req", bus_req, (ph != 0));
      chk(bus_lock == (ph >= 2), "R6", "bus_lock", bus_lock, (ph >= 2));
      chk(bus_cmd_valid == (ph >= 2 && bus_gnt), "R3", "bus_cmd_valid", bus_cmd_valid, (ph >= 2 && bus_gnt));
      if (bus_cmd_valid) begin
        chk(bus_we == (ph == 3), "R4", "bus_we", bus_we, (ph == 3));
        chk(bus_addr == e_addr, "R4", "bus_addr", bus_addr, e_addr);
        if (bus_we) chk(bus_wdata == e_wdata, "R5", "bus_wdata", bus_wdata, e_wdata);
      end
      chk(rsp_done == (ph == 3 && bus_gnt && bus_ack), "R7", "rsp_done", rsp_done, (ph == 3 && bus_gnt && bus_ack));
      if (rsp_done) begin
        chk(rsp_old == rd_val, "R7", "rsp_old", rsp_old, rd_val);
        last_old = rsp_old; n_done++; unit_done_cyc = cycle;
      end
      // R8: competitor never owns the bus while the unit holds its lock
      if (owner == 2) chk(!bus_lock, "R8", "competitor granted under lock", bus_lock, 0);
    end
  end

  // arbiter and memory model
  always @(negedge clk) begin
    bit dropped;
    dropped = 1'b0;
    if (ack_on) begin
      ack_on = 1'b0; dropped = 1'b1; lat_cnt = 0;
      if (owner == 2) begin owner = 0; comp_served++; comp_end_cyc = cycle; end
      else if (owner == 1 && !bus_lock) owner = 0;
    end
    if (owner == 1 && !bus_req) owner = 0;
    if (owner == 0) begin
      if (comp_served < comp_req_cnt) owner = 2;
      else if (bus_req) owner = 1;
    end
    if (!dropped) begin
      if (owner == 1 && bus_cmd_valid) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin
          ack_on = 1'b1;
          bus_rdata = mem[bus_addr[3:0]];
          if (bus_we) mem[bus_addr[3:0]] = bus_wdata;
        end
      end else if (owner == 2) begin
        lat_cnt++;
        if (lat_cnt >= lat) begin
          ack_on = 1'b1;
          mem[comp_addr] = comp_val;
        end
      end
    end
    bus_gnt = (owner == 1);
    bus_ack = ack_on && (owner == 1);
  end

  task automatic atomic(input logic op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] old);
    int start;
    start = n_done;
    @(negedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    do @(negedge clk); while (ph == 0);
    #1 req_valid = 1'b0;
    wait (n_done != start);
    old = last_old;
  endtask

  initial begin
    logic [DW-1:0] old;
    for (int i = 0; i < 16; i++) mem[i] = 32'h1000_0000 + i;
    mem[5] = '0; mem[7] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_addr = '0; req_wdata = '0;
    bus_gnt = 1'b0; bus_ack = 1'b0; bus_rdata = '0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 swap, fast ack
    lat = 1;
    atomic(1'b0, 16'd3, 32'hA5A5_0001, old);
    chk(old == 32'h1000_0003, "R7", "swap old value", old, 32'h1000_0003);
    chk(mem[3] == 32'hA5A5_0001, "R5", "swap stored", mem[3], 32'hA5A5_0001);

    // R10 test-and-set acquire then fail, slow ack
    lat = 4;
    atomic(1'b1, 16'd5, 32'h0, old);
    chk(old == 0, "R10", "first tas returns free", old, 0);
    chk(mem[5] == 1, "R10", "first tas sets lock", mem[5], 1);
    atomic(1'b1, 16'd5, 32'h0, old);
    chk(old == 1, "R10", "second tas returns held", old, 1);
    chk(mem[5] == 1, "R10", "second tas keeps lock", mem[5], 1);

    // R5 test-and-set ignores supplied data
    atomic(1'b1, 16'd6, 32'hFFFF_FFF0, old);
    chk(mem[6] == 1, "R5", "tas writes one", mem[6], 1);

    // R3 competitor owns the bus first; unit must wait for grant
    lat = 5; comp_addr = 4'd2; comp_val = 32'h0000_BEEF;
    @(negedge clk); #1 comp_req_cnt++;
    atomic(1'b0, 16'd2, 32'h77, old);
    chk(old == 32'h0000_BEEF, "R3", "unit waited for competitor", old, 32'h0000_BEEF);
    chk(mem[2] == 32'h77, "R3", "unit write after competitor", mem[2], 32'h77);

    // R8 competitor arrives while the locked pair is under way
    lat = 3; comp_addr = 4'd7; comp_val = 32'h0;
    fork
      atomic(1'b1, 16'd7, 32'h0, old);
      begin
        wait (ph == 2);
        @(negedge clk); #1 comp_req_cnt++;
      end
    join
    wait (comp_served == comp_req_cnt);
    chk(old == 0, "R8", "tas old under contention", old, 0);
    chk(mem[7] == 0, "R8", "competitor write lands last", mem[7], 0);
    chk(comp_end_cyc > unit_done_cyc, "R8", "competitor completes after pair",
        comp_end_cyc, unit_done_cyc);

    // R9 request while busy is ignored
    lat = 6;
    fork
      atomic(1'b0, 16'd4, 32'h44, old);
      begin
        wait (ph == 2);
        @(negedge clk); #1;
        req_valid = 1'b1; req_op = 1'b0; req_addr = 16'd9; req_wdata = 32'hDEAD;
        repeat (2) @(negedge clk);
        #1 req_valid = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    chk(old == 32'h1000_0004, "R9", "busy swap old", old, 32'h1000_0004);
    chk(mem[4] == 32'h44, "R9", "busy swap stored", mem[4], 32'h44);
    chk(mem[9] == 32'h1000_0009, "R9", "ignored request touched nothing", mem[9], 32'h1000_0009);
    chk(ph == 0 && req_ready, "R9", "idle after ignored request", req_ready, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule